// File: doc/BRIEF.md
# EDO DRAM Byte-Lane Access Sequencer

This block turns single read or write requests from a host into one complete random-access cycle on an asynchronous 64K x 16 extended-data-out DRAM with a multiplexed address bus. The host offers a 16-bit word address, 16-bit write data, one enable per byte lane and a direction bit, using a valid/ready handshake. The sequencer presents the upper address half as the row while the row strobe falls. It then presents the lower half as the column while the column strobes of the selected lanes are low. Read data is captured and returned with a single-cycle response pulse.

Every phase length is a whole number of clock cycles set by a parameter: the row-to-column delay, the column strobe width, the access time from the column strobe, the row hold after the column strobes rise, the row precharge and the minimum total cycle. The column phase lasts the longer of the strobe width and the access time. Precharge is stretched when that is needed to meet the minimum total cycle. A separate refresh scheduler can hold off new requests through `refresh_hold`. A cycle that is already running always completes.

Top module: `edo_lane_sequencer`

## Requirements
- R1: `req_ready` is high only when no cycle is in progress (row strobe high, no precharge pending) and `refresh_hold` is low. A request is taken at a clock edge where `req_valid` and `req_ready` are both high.
- R2: After acceptance the row strobe is low for ROW_N = T_RCD cycles with the row (address bits 15..8) on `mem_addr` and all column strobes high. The column (address bits 7..0) is then on `mem_addr` for the column and hold phases. A column strobe is never low while the row strobe is high.
- R3: `mem_cas_n[0]` serves byte lane 0 (data bits 7..0) and goes low only if `req_be[0]` was set. `mem_cas_n[1]` serves lane 1 (bits 15..8) and goes low only if `req_be[1]` was set. An unselected strobe stays high for the whole cycle.
- R4: Each selected column strobe is low for exactly COL_N = max(T_CAS, T_CAC) consecutive cycles.
- R5: For a write, `mem_we_n` is low from the first row cycle to the end of the hold phase, so it falls before any column strobe. `mem_oe_n` stays high. Only selected lanes drive `mem_dq_oe`/`mem_dq_out`, and each carries its byte of the write data.
- R6: For a read, `mem_we_n` stays high and `mem_oe_n` is low exactly during the column phase. `mem_dq_in` is sampled on the last column cycle and returned on `rsp_rdata` with `rsp_valid` high for exactly the following cycle. Unselected lanes read as zero.
- R7: After the column phase the row strobe stays low for HOLD_N = T_RSH cycles. It is then high for PRE_N = max(T_RP, T_RC - ROW_N - COL_N - HOLD_N) cycles. `req_ready` stays low during this time, and a request offered during precharge is accepted only afterwards.
- R8: While `refresh_hold` is high, no request is accepted and the row strobe does not fall. Raising it during a cycle does not shorten or change that cycle.
- R9: After reset all strobes, `mem_we_n` and `mem_oe_n` are high, no lane is driven, `rsp_valid` is low and `req_ready` is high while `refresh_hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address, row in the upper half |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| refresh_hold | input | 1 | Blocks acceptance of new requests |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 2 | Column strobe per lane, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 8 | Multiplexed row/column address |
| mem_dq_out | output | 16 | Data driven to the DRAM |
| mem_dq_oe | output | 2 | Per-lane data drive enable |
| mem_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The assertions check on every cycle that column strobes stay inside the row-strobe window and only on selected lanes, and that write enable is already low one cycle before any strobe falls on a write. They also check that output enable never overlaps a write drive, that strobe width and precharge length match the derived counts, that the response is a single pulse, and that the hold input masks ready. Only the bench scenarios show that the right row and column reach the pins in the right phases, and that byte writes leave the other lane intact when read back. They also show that read data is taken on the last column cycle, after the modelled access delay, and not earlier, and that a request offered during precharge or under hold is taken at the right later edge.

// File: rtl/edo_seq_pkg.sv
// Shared types for the EDO DRAM sequencer.
// Assumes: phases are ordered IDLE, ROW, COL, HOLD, PRE and then back to IDLE.
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_HOLD = 3'd3,
        ST_PRE  = 3'd4
    } edo_phase_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_seq_phase_fsm.sv
// Phase sequencer: steps through the cycle phases, each held for its count.
// Assumes: every length parameter is at least 1; start is honoured in IDLE only.
module edo_seq_phase_fsm
    import edo_seq_pkg::*;
#(
    parameter int unsigned ROW_N  = 2,
    parameter int unsigned COL_N  = 3,
    parameter int unsigned HOLD_N = 1,
    parameter int unsigned PRE_N  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output edo_phase_t phase,
    output logic       col_last
);
    localparam int unsigned LEN_MAX = imax(imax(ROW_N, COL_N), imax(HOLD_N, PRE_N));
    localparam int unsigned CNT_W   = (LEN_MAX < 2) ? 1 : $clog2(LEN_MAX);

    logic [CNT_W-1:0] remain;
    wire              expired = (remain == '0);

    // Phase register and down-counter of cycles left in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= ST_IDLE;
            remain <= '0;
        end else begin
            unique case (phase)
                ST_IDLE: if (start) begin
                    phase  <= ST_ROW;
                    remain <= CNT_W'(ROW_N - 1);
                end
                ST_ROW: if (expired) begin
                    phase  <= ST_COL;
                    remain <= CNT_W'(COL_N - 1);
                end else remain <= remain - 1'b1;
                ST_COL: if (expired) begin
                    phase  <= ST_HOLD;
                    remain <= CNT_W'(HOLD_N - 1);
                end else remain <= remain - 1'b1;
                ST_HOLD: if (expired) begin
                    phase  <= ST_PRE;
                    remain <= CNT_W'(PRE_N - 1);
                end else remain <= remain - 1'b1;
                ST_PRE: if (expired) phase <= ST_IDLE;
                        else remain <= remain - 1'b1;
                default: phase <= ST_IDLE;
            endcase
        end
    end

    // Last cycle of the column phase, when read data is taken.
    assign col_last = (phase == ST_COL) && expired;

endmodule

// File: rtl/edo_seq_addr_mux.sv
// Row/column multiplexer for the shared DRAM address pins.
// Assumes: the word address is twice the pin width, with the row in the upper half.
module edo_seq_addr_mux #(
    parameter int unsigned PIN_W = 8
) (
    input  logic [2*PIN_W-1:0] word_addr,
    input  logic               col_sel,
    output logic [PIN_W-1:0]   pin_addr
);
    // Choose the column half once the column phase starts.
    always_comb begin
        pin_addr = col_sel ? word_addr[PIN_W-1:0] : word_addr[2*PIN_W-1:PIN_W];
    end
endmodule

// File: rtl/edo_seq_lane.sv
// One byte lane: its column strobe, write drive and read capture.
// Assumes: sel, wr and wbyte hold steady for the whole cycle.
module edo_seq_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr,
    input  logic       in_col,
    input  logic       active,
    input  logic       capture,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_in,
    output logic       cas_n,
    output logic       dq_oe,
    output logic [7:0] dq_out,
    output logic [7:0] rbyte
);
    // Strobe low only for a selected lane in the column phase.
    assign cas_n  = !(in_col && sel);
    // Drive data for a selected lane through the whole write cycle.
    assign dq_oe  = active && wr && sel;
    assign dq_out = wbyte;

    // Take the lane's read byte; an unselected lane returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       rbyte <= '0;
        else if (capture) rbyte <= sel ? dq_in : 8'h00;
    end
endmodule

// File: rtl/edo_lane_sequencer.sv
// Top: single random-access cycles on a 64K x 16 EDO DRAM with byte-lane strobes.
// Assumes: timing parameters are clock counts >= 1; refresh is issued elsewhere
// and gated by refresh_hold; DATA_W is a multiple of 8.
module edo_lane_sequencer
    import edo_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned T_RCD  = 2,
    parameter int unsigned T_CAS  = 2,
    parameter int unsigned T_CAC  = 3,
    parameter int unsigned T_RSH  = 1,
    parameter int unsigned T_RP   = 2,
    parameter int unsigned T_RC   = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_be,
    input  logic                   refresh_hold,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   mem_ras_n,
    output logic [DATA_W/8-1:0]    mem_cas_n,
    output logic                   mem_we_n,
    output logic                   mem_oe_n,
    output logic [ADDR_W/2-1:0]    mem_addr,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic [DATA_W/8-1:0]    mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in
);
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned PIN_W  = ADDR_W / 2;
    localparam int unsigned ROW_N  = T_RCD;
    localparam int unsigned COL_N  = imax(T_CAS, T_CAC);
    localparam int unsigned HOLD_N = T_RSH;
    localparam int unsigned BUSY_N = ROW_N + COL_N + HOLD_N;
    localparam int unsigned PRE_N  = imax(T_RP, (T_RC > BUSY_N) ? (T_RC - BUSY_N) : 0);

    edo_phase_t          phase;
    logic                col_last;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    be_q;
    logic                wr_q;

    wire accept  = req_valid && req_ready;
    wire in_col  = (phase == ST_COL);
    wire active  = (phase == ST_ROW) || in_col || (phase == ST_HOLD);
    wire capture = col_last && !wr_q;

    // Ready only while idle and not held off by the refresh scheduler.
    assign req_ready = (phase == ST_IDLE) && !refresh_hold;

    // Latch the request when it is accepted; it stays fixed for the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            wr_q    <= req_write;
        end
    end

    edo_seq_phase_fsm #(
        .ROW_N (ROW_N),
        .COL_N (COL_N),
        .HOLD_N(HOLD_N),
        .PRE_N (PRE_N)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .phase   (phase),
        .col_last(col_last)
    );

    edo_seq_addr_mux #(.PIN_W(PIN_W)) u_amux (
        .word_addr(addr_q),
        .col_sel  (in_col || (phase == ST_HOLD)),
        .pin_addr (mem_addr)
    );

    // Row strobe low for the whole active window; control lines by direction.
    assign mem_ras_n = !active;
    assign mem_we_n  = !(active && wr_q);
    assign mem_oe_n  = !(in_col && !wr_q);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        edo_seq_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (be_q[l]),
            .wr     (wr_q),
            .in_col (in_col),
            .active (active),
            .capture(capture),
            .wbyte  (wdata_q[l*8 +: 8]),
            .dq_in  (mem_dq_in[l*8 +: 8]),
            .cas_n  (mem_cas_n[l]),
            .dq_oe  (mem_dq_oe[l]),
            .dq_out (mem_dq_out[l*8 +: 8]),
            .rbyte  (rsp_rdata[l*8 +: 8])
        );
    end

    // One-cycle response pulse after the read capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= capture;
    end

endmodule

// File: rtl/edo_lane_sequencer_checks.sv
// Protocol checker for the sequencer pins, bound into every instance.
// Assumes: the lane-select input is the latched byte enable of the cycle.
module edo_lane_sequencer_checks #(
    parameter int unsigned LANES = 2,
    parameter int unsigned COL_N = 3,
    parameter int unsigned PRE_N = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [LANES-1:0] dq_oe,
    input logic             rsp_valid,
    input logic             req_ready,
    input logic             refresh_hold,
    input logic [LANES-1:0] lane_sel
);
    wire cas_any = !(&cas_n);
    logic        cas_prev;
    logic [15:0] cas_len;
    logic        ras_prev_hi;
    logic [15:0] ras_hi_len;

    // Length of the current low stretch of the column strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_prev <= 1'b0;
            cas_len  <= '0;
        end else begin
            cas_prev <= cas_any;
            cas_len  <= cas_any ? cas_len + 16'd1 : 16'd0;
        end
    end

    // Length of the current high stretch of the row strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev_hi <= 1'b1;
            ras_hi_len  <= 16'(PRE_N);
        end else begin
            ras_prev_hi <= ras_n;
            if (!ras_n)                      ras_hi_len <= '0;
            else if (ras_hi_len < 16'(PRE_N)) ras_hi_len <= ras_hi_len + 16'd1;
        end
    end

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && !cas_any));
    p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_any |-> !ras_n);
    p_lane_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cas_n) & ~lane_sel) == '0);
    p_cas_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_prev && !cas_any) |-> (cas_len == 16'(COL_N)));
    p_we_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_any && !cas_prev && !we_n) |-> ($past(we_n) == 1'b0));
    p_no_oe_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dq_oe) || !we_n) |-> oe_n);
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_prev_hi && !ras_n) |-> (ras_hi_len >= 16'(PRE_N)));
    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_hold |-> !req_ready);

endmodule

bind edo_lane_sequencer edo_lane_sequencer_checks #(
    .LANES(LANES),
    .COL_N(COL_N),
    .PRE_N(PRE_N)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_n       (mem_ras_n),
    .cas_n       (mem_cas_n),
    .we_n        (mem_we_n),
    .oe_n        (mem_oe_n),
    .dq_oe       (mem_dq_oe),
    .rsp_valid   (rsp_valid),
    .req_ready   (req_ready),
    .refresh_hold(refresh_hold),
    .lane_sel    (be_q)
);

// File: tb/edo_lane_sequencer_test.sv
// Directed bench: a small DRAM model and one task per scenario.
`timescale 1ns/1ps
module edo_lane_sequencer_test;
    localparam int T_CAC  = 3;
    localparam int ROW_N  = 2;
    localparam int COL_N  = 3;   // max(T_CAS=2, T_CAC=3)
    localparam int HOLD_N = 1;
    localparam int PRE_N  = 3;   // max(T_RP=2, T_RC=9 - 6)
    localparam int TOTAL  = ROW_N + COL_N + HOLD_N + PRE_N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, refresh_hold = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid, mem_ras_n, mem_we_n, mem_oe_n;
    logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [1:0]  mem_cas_n, mem_dq_oe;
    logic [7:0]  mem_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    edo_lane_sequencer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .refresh_hold(refresh_hold), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // DRAM model: row latched on the row strobe, data valid T_CAC cycles into the strobe.
    logic [15:0] model [0:255];
    logic [15:0] shadow [0:255];
    logic [7:0]  row_m = '0;
    int          cas_cnt = 0;

    always @(negedge mem_ras_n) row_m <= mem_addr;
    always @(posedge clk) begin
        cas_cnt <= (&mem_cas_n) ? 0 : cas_cnt + 1;
        for (int l = 0; l < 2; l++)
            if (!mem_we_n && !mem_cas_n[l])
                model[row_m ^ mem_addr][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
    end
    for (genvar l = 0; l < 2; l++) begin : g_dq
        assign mem_dq_in[l*8 +: 8] =
            (!mem_oe_n && !mem_cas_n[l] && cas_cnt >= T_CAC - 1)
            ? model[row_m ^ mem_addr][l*8 +: 8] : 8'hA5;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One complete cycle, checked pin by pin at every falling edge.
    task automatic run_req(input bit wr, input logic [1:0] be, input logic [15:0] a,
                           input logic [15:0] wd, input bit hold_mid, input bit pre_next);
        logic [15:0] exp_rd;
        int idx;
        bit in_row, in_col, in_hold, act;
        idx = a[15:8] ^ a[7:0];
        exp_rd = {be[1] ? shadow[idx][15:8] : 8'h00, be[0] ? shadow[idx][7:0] : 8'h00};
        req_write = wr; req_be = be; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t <= TOTAL; t++) begin
            in_row  = (t < ROW_N);
            in_col  = (t >= ROW_N) && (t < ROW_N + COL_N);
            in_hold = (t >= ROW_N + COL_N) && (t < ROW_N + COL_N + HOLD_N);
            act     = in_row || in_col || in_hold;
            chk(mem_ras_n == !act, "R7", $sformatf("ras_n t=%0d", t), mem_ras_n, !act);
            if (in_row) chk(mem_addr == a[15:8], "R2", "row addr", mem_addr, a[15:8]);
            if (in_col || in_hold) chk(mem_addr == a[7:0], "R2", "col addr", mem_addr, a[7:0]);
            chk(mem_cas_n == ~(be & {2{in_col}}), "R3", $sformatf("cas_n t=%0d", t),
                mem_cas_n, ~(be & {2{in_col}}));
            chk(mem_we_n == !(wr && act), "R5", $sformatf("we_n t=%0d", t), mem_we_n, !(wr && act));
            chk(mem_oe_n == !(!wr && in_col), "R6", $sformatf("oe_n t=%0d", t),
                mem_oe_n, !(!wr && in_col));
            chk(mem_dq_oe == (be & {2{wr && act}}), "R5", $sformatf("dq_oe t=%0d", t),
                mem_dq_oe, be & {2{wr && act}});
            if (wr && act) chk(mem_dq_out == wd, "R5", "dq_out", mem_dq_out, wd);
            chk(rsp_valid == (!wr && t == ROW_N + COL_N), "R6", $sformatf("rsp_valid t=%0d", t),
                rsp_valid, !wr && t == ROW_N + COL_N);
            if (!wr && t == ROW_N + COL_N) chk(rsp_rdata == exp_rd, "R6", "read data", rsp_rdata, exp_rd);
            chk(req_ready == (t == TOTAL && !refresh_hold), "R1", $sformatf("ready t=%0d", t),
                req_ready, t == TOTAL && !refresh_hold);
            if (hold_mid && t == 1) refresh_hold = 1'b1;
            if (pre_next && t == ROW_N + COL_N + HOLD_N) req_valid = 1'b1;
            if (t < TOTAL) @(negedge clk);
        end
        if (hold_mid) begin
            chk(!req_ready, "R8", "ready under hold after cycle", req_ready, 0);
            refresh_hold = 1'b0;
        end
        if (wr) begin
            if (be[0]) shadow[idx][7:0]  = wd[7:0];
            if (be[1]) shadow[idx][15:8] = wd[15:8];
        end
    endtask

    task automatic t_reset_state();
        chk(mem_ras_n && (&mem_cas_n) && mem_we_n && mem_oe_n, "R9", "strobes idle",
            {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 5'h1F);
        chk(mem_dq_oe == 2'b00 && !rsp_valid, "R9", "no drive, no rsp", {mem_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R9", "ready after reset", req_ready, 1);
    endtask

    task automatic t_word_write_read();   // R2 R4 R5 R6 R7
        run_req(1'b1, 2'b11, 16'h5A3C, 16'h1234, 1'b0, 1'b0);
        run_req(1'b0, 2'b11, 16'h5A3C, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_lower_lane_write();  // R3: upper lane must survive
        run_req(1'b1, 2'b01, 16'h5A3C, 16'hFFEE, 1'b0, 1'b0);
        run_req(1'b0, 2'b11, 16'h5A3C, 16'h0000, 1'b0, 1'b0);
        chk(rsp_rdata == 16'h12EE, "R3", "upper byte kept", rsp_rdata, 16'h12EE);
    endtask

    task automatic t_upper_lane_read();   // R3 R6: lower byte reads zero
        run_req(1'b1, 2'b10, 16'h0307, 16'hC4B5, 1'b0, 1'b0);
        run_req(1'b0, 2'b10, 16'h0307, 16'h0000, 1'b0, 1'b0);
        chk(rsp_rdata[7:0] == 8'h00, "R6", "unselected lane zero", rsp_rdata[7:0], 0);
    endtask

    task automatic t_refresh_hold();      // R8
        refresh_hold = 1'b1;
        req_write = 1'b0; req_be = 2'b11; req_addr = 16'h2211; req_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!req_ready && mem_ras_n, "R8", "held off", {req_ready, mem_ras_n}, 2'b01);
        end
        refresh_hold = 1'b0;
        run_req(1'b0, 2'b11, 16'h2211, 16'h0000, 1'b0, 1'b0);
        run_req(1'b1, 2'b11, 16'h7788, 16'hBEEF, 1'b1, 1'b0);  // R8 hold raised mid-cycle
        run_req(1'b0, 2'b11, 16'h7788, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_request_in_precharge();  // R7
        run_req(1'b1, 2'b11, 16'h4040, 16'hA55A, 1'b0, 1'b1);
        run_req(1'b1, 2'b11, 16'h4040, 16'hA55A, 1'b0, 1'b0);
        run_req(1'b0, 2'b01, 16'h4040, 16'h0000, 1'b0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            model[i]  = {8'(i) ^ 8'h3C, 8'(i)};
            shadow[i] = {8'(i) ^ 8'h3C, 8'(i)};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_word_write_read();
        t_lower_lane_write();
        t_upper_lane_read();
        t_refresh_hold();
        t_request_in_precharge();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule